// File: doc/BRIEF.md
# Bipolar AMI Line Encoder with Deliberate Violation Insertion

This block turns a serial NRZ bit stream into alternate-mark-inversion pulses on two rails. One bit is taken in each clock cycle in which `bit_en` is high. A one bit becomes a mark on the rail opposite to the previous mark. A zero bit drives neither rail. Each rail pulse is registered: it appears in the clock cycle after the enabled bit and lasts exactly one clock.

On command, the block inserts one bipolar violation to exercise error counters further down the line. A rising edge on `inject_req` arms the insertion. The block then waits for three contiguous one bits and sends the third with the same polarity as the mark before it. `bpv_flag` marks that pulse. The arm state is held by a two-state machine: `ST_IDLE` (not armed) and `ST_HUNT` (armed, counting ones). The transitions are *arm* (ST_IDLE to ST_HUNT on a rising edge of the request), *fire* (ST_HUNT to ST_IDLE when the violating mark is emitted), and *re-arm on fire* (stay in ST_HUNT when a new rising edge arrives in the firing cycle). Inside ST_HUNT a run counter advances on each one bit and clears on each zero bit.

Top module: `ami_bpv_encoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `pos_out`, `neg_out` and `bpv_flag` are 0. Reset disarms the block, clears the run count and the request edge history, and sets the last-mark polarity to negative, so the first one bit after reset leaves on `pos_out`.
- R2: A bit presented with `bit_en`=1 in cycle N shows at the outputs in cycle N+1 for one cycle. A one bit raises exactly one rail, opposite to the previous mark. A zero bit raises neither rail.
- R3: In a cycle after one with `bit_en`=0, both rails and `bpv_flag` are 0, and the polarity and arm state do not change.
- R4: `inject_req` is sampled every clock, and only a 0-to-1 change arms an insertion. A level held high arms nothing more. With no arming, any run of ones gives strictly alternating marks.
- R5: Once armed, the third one bit in a contiguous run of enabled one bits, counted from the first enabled bit after the arming edge, is sent as the violation.
- R6: An enabled zero bit restarts the count while armed. Bits in cycles with `bit_en`=0 neither count nor break the run.
- R7: The violating mark has the same polarity as the mark before it. Later marks alternate starting from the violating mark.
- R8: `bpv_flag` is 1 for exactly the cycle that carries the violating mark. Each arming yields one violation, after which the block is disarmed.
- R9: A further violation needs `inject_req` to go back to 0 and then rise to 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit strobe: take `data_in` this cycle |
| data_in | input | 1 | NRZ data bit |
| inject_req | input | 1 | Insertion request; its rising edge arms a violation |
| pos_out | output | 1 | Positive-rail mark pulse |
| neg_out | output | 1 | Negative-rail mark pulse |
| bpv_flag | output | 1 | High with the injected violating mark |

## Verification
A wrong polarity register appears at the ports as two same-rail marks without `bpv_flag`, on the very next one bit. A wrong run count or arm state shows up as a violation that is early, late, missing or repeated. Its position in the bit stream reveals the fault within three enabled bits of the wrong value. An edge detector that acts on level would give a second violation while the request is held high. The bench keeps its own model of polarity and arming and compares every bit's rails and flag.

// File: rtl/ami_pkg.sv
package ami_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HUNT = 1'b1
    } arm_state_t;

    typedef enum logic {
        POL_NEG = 1'b0,
        POL_POS = 1'b1
    } mark_pol_t;

    function automatic mark_pol_t flip_pol(input mark_pol_t p);
        return (p == POL_POS) ? POL_NEG : POL_POS;
    endfunction

endpackage

// File: rtl/ami_rise_detect.sv
module ami_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_i;
        end
    end

    always_comb begin
        rise_o = level_i & ~level_q;
    end
endmodule

// File: rtl/ami_arm_fsm.sv
module ami_arm_fsm
    import ami_pkg::*;
#(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic bit_en_i,
    input  logic data_i,
    output logic fire_o
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(RUN_LEN - 1);

    arm_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          fire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // firing condition: armed, enabled one bit, run complete
    always_comb begin
        fire = (state_q == ST_HUNT) && bit_en_i && data_i && (cnt_q == LAST_CNT);
    end

    // next state and run count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (rise_i) begin
                    state_d = ST_HUNT;
                end
            end
            ST_HUNT: begin
                if (fire) begin
                    cnt_d   = '0;
                    state_d = rise_i ? ST_HUNT : ST_IDLE;
                end else if (bit_en_i) begin
                    cnt_d = data_i ? cnt_q + 1'b1 : '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        fire_o = fire;
    end
endmodule

// File: rtl/ami_mark_gen.sv
module ami_mark_gen
    import ami_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en_i,
    input  logic data_i,
    input  logic fire_i,
    output logic pos_o,
    output logic neg_o,
    output logic flag_o
);
    mark_pol_t last_q;
    mark_pol_t mark_pol;

    always_comb begin
        mark_pol = fire_i ? last_q : flip_pol(last_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= POL_NEG;
            pos_o  <= 1'b0;
            neg_o  <= 1'b0;
            flag_o <= 1'b0;
        end else if (bit_en_i && data_i) begin
            last_q <= mark_pol;
            pos_o  <= (mark_pol == POL_POS);
            neg_o  <= (mark_pol == POL_NEG);
            flag_o <= fire_i;
        end else begin
            pos_o  <= 1'b0;
            neg_o  <= 1'b0;
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/ami_bpv_encoder.sv
module ami_bpv_encoder #(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic data_in,
    input  logic inject_req,
    output logic pos_out,
    output logic neg_out,
    output logic bpv_flag
);
    logic req_rise;
    logic fire;

    ami_rise_detect u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (inject_req),
        .rise_o  (req_rise)
    );

    ami_arm_fsm #(.RUN_LEN(RUN_LEN)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (req_rise),
        .bit_en_i (bit_en),
        .data_i   (data_in),
        .fire_o   (fire)
    );

    ami_mark_gen u_marks (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en_i (bit_en),
        .data_i   (data_in),
        .fire_i   (fire),
        .pos_o    (pos_out),
        .neg_o    (neg_out),
        .flag_o   (bpv_flag)
    );
endmodule

// File: rtl/ami_bpv_checker.sv
module ami_bpv_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic data_in,
    input logic inject_req,
    input logic pos_out,
    input logic neg_out,
    input logic bpv_flag
);
    logic ck_last_pos;
    logic unused_req;

    assign unused_req = inject_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_last_pos <= 1'b0;
        end else if (pos_out) begin
            ck_last_pos <= 1'b1;
        end else if (neg_out) begin
            ck_last_pos <= 1'b0;
        end
    end

    // R2
    one_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pos_out && neg_out));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> (!pos_out && !neg_out && !bpv_flag));

    // R2
    zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !data_in) |=> (!pos_out && !neg_out));

    // R2
    alt_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_out && !bpv_flag) |-> !ck_last_pos);

    // R2
    alt_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_out && !bpv_flag) |-> ck_last_pos);

    // R7
    viol_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bpv_flag |-> ((pos_out && ck_last_pos) || (neg_out && !ck_last_pos)));

    // R8
    flag_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bpv_flag |=> !bpv_flag);
endmodule

bind ami_bpv_encoder ami_bpv_checker u_bpv_chk (.*);

// File: tb/test_ami_bpv_encoder.sv
`timescale 1ns/1ps
module test_ami_bpv_encoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic data_in = 1'b0;
    logic inject_req = 1'b0;
    logic pos_out, neg_out, bpv_flag;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model
    bit m_last_pos = 0;
    bit m_armed = 0;
    int m_run = 0;

    always #2.5 clk = ~clk;

    ami_bpv_encoder i_ami_bpv_encoder (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .data_in(data_in),
        .inject_req(inject_req), .pos_out(pos_out), .neg_out(neg_out),
        .bpv_flag(bpv_flag)
    );

    task automatic chk(input string req, input string what, input logic [2:0] act,
                       input logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual {pos,neg,flag}=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_en = 1'b0;
        data_in = 1'b0;
        inject_req = 1'b0;
        m_last_pos = 0; m_armed = 0; m_run = 0;
        @(negedge clk);
        chk("R1", "outputs in reset", {pos_out, neg_out, bpv_flag}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset", {pos_out, neg_out, bpv_flag}, 3'b000);
    endtask

    task automatic set_req(input bit v);
        @(negedge clk);
        if (v && !inject_req) begin
            if (!m_armed) m_run = 0;
            m_armed = 1;
        end
        inject_req = v;
    endtask

    task automatic send_bit(input bit d, input string req);
        logic [2:0] exp;
        @(negedge clk);
        bit_en = 1'b1;
        data_in = d;
        exp = 3'b000;
        if (d) begin
            if (m_armed && m_run == 2) begin
                exp = {m_last_pos, !m_last_pos, 1'b1};
                m_armed = 0;
                m_run = 0;
            end else begin
                m_last_pos = !m_last_pos;
                exp = {m_last_pos, !m_last_pos, 1'b0};
                if (m_armed) m_run++;
            end
        end else begin
            m_run = 0;
        end
        @(negedge clk);
        bit_en = 1'b0;
        chk(req, d ? "one bit" : "zero bit", {pos_out, neg_out, bpv_flag}, exp);
    endtask

    task automatic send_seq(input int n, input logic [31:0] bits, input string req);
        for (int i = n - 1; i >= 0; i--) send_bit(bits[i], req);
    endtask

    task automatic idle_gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R3", "no bit_en", {pos_out, neg_out, bpv_flag}, 3'b000);
        end
    endtask

    // R1, R2, R4: plain alternating AMI with no arming
    task automatic t_plain();
        send_bit(1, "R1");
        send_seq(8, 32'b1101_1110, "R2");
        send_seq(5, 32'b11111, "R4");
    endtask

    // R5, R6, R7, R8: arm then broken run, then full run
    task automatic t_arm_basic();
        set_req(1);
        send_seq(5, 32'b11011, "R6");
        send_bit(1, "R5");
        send_seq(4, 32'b1111, "R7");
        send_seq(6, 32'b111111, "R8");
    endtask

    // R3: gaps inside a run neither break nor count
    task automatic t_gaps();
        set_req(0);
        set_req(1);
        send_bit(1, "R6");
        idle_gap(3);
        send_bit(1, "R6");
        idle_gap(2);
        send_bit(1, "R5");
        send_seq(3, 32'b111, "R7");
    endtask

    // R4, R9: level high no re-arm; drop and raise re-arms
    task automatic t_rearm();
        send_seq(6, 32'b111111, "R4");
        set_req(0);
        send_seq(4, 32'b1111, "R9");
        set_req(1);
        send_seq(4, 32'b1111, "R9");
    endtask

    // R4: short pulse arms; R1: reset disarms
    task automatic t_pulse_and_reset();
        set_req(1);
        set_req(0);
        send_seq(4, 32'b1011, "R4");
        send_bit(1, "R4");
        set_req(1);
        set_req(0);
        do_reset();
        send_seq(5, 32'b11111, "R1");
    endtask

    initial begin
        do_reset();
        t_plain();
        t_arm_basic();
        t_gaps();
        t_rearm();
        t_pulse_and_reset();
        idle_gap(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule